// File: doc/BRIEF.md
# FIFO Threshold Host Interrupt Trigger

This block holds a byte-wide transmit queue and an interrupt toward an external host that fires once the queue holds enough bytes for a read to proceed without stalling. A DMA-style push strobe fills the queue and a host-side pop strobe drains it. Local software writes a byte threshold before it starts moving a packet. That write arms the trigger. The first time the armed trigger sees occupancy at or above the threshold, it raises the host interrupt and disarms itself. After that, occupancy changes raise nothing until software writes the threshold again.

The host lowers its interrupt by strobing a clear. Once it has read the data, the host strobes an acknowledge write that carries an ack/nack bit. That write raises a pending interrupt toward local software and latches the bit as status. Software clears its interrupt with a strobe of its own, and can then re-arm for the next packet. If enough bytes are already queued when software re-arms, the host interrupt fires straight away.

Top module: `host_thresh_irq`

## Requirements
- R1: A software threshold write stores the value clamped to the range 1..BLOCK_MAX (0 becomes 1, anything above 128 becomes 128 by default). The stored value appears on `thr_value` and `trig_armed` reads 1 in the next cycle, unless R5 applies.
- R2: While armed, one cycle after `occupancy` shows a value at or above the threshold, `host_irq` is 1 and `trig_armed` is 0.
- R3: While disarmed, occupancy reaching or passing the threshold leaves `host_irq` and `trig_armed` unchanged.
- R4: A host clear strobe drives `host_irq` to 0 in the next cycle when no fire condition is present. The clear leaves `trig_armed` unchanged.
- R5: A threshold write made while occupancy already meets the clamped new value sets `host_irq` to 1 in the next cycle and leaves the trigger disarmed.
- R6: When a host clear and a fire condition (from the armed compare or from a threshold write) occur in the same cycle, `host_irq` is 1 in the next cycle.
- R7: A host acknowledge write sets `sw_irq` to 1 in the next cycle, and `ack_status` then equals the written bit (1 = ack, 0 = nack).
- R8: A software clear strobe drives `sw_irq` to 0 in the next cycle, unless an acknowledge write arrives in the same cycle, in which case `sw_irq` stays 1.
- R9: Bytes leave in the order they were pushed. Popped data appears on `pop_data` with `pop_valid` 1 in the cycle after the pop strobe, and `occupancy` tracks accepted pushes minus accepted pops.
- R10: A push when the queue holds DEPTH bytes is dropped and sets the sticky `overflow_flag`. A pop when the queue is empty is dropped, sets the sticky `underflow_flag` and leaves `pop_valid` at 0.
- R11: After reset, `occupancy` is 0, all interrupts, flags and `trig_armed` are 0, and `thr_value` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_thr_we | input | 1 | Software threshold write strobe (arms) |
| sw_thr_val | input | 8 | Threshold value in bytes |
| sw_irq_clr | input | 1 | Software interrupt clear strobe |
| push_en | input | 1 | Push one byte into the queue |
| push_data | input | 8 | Byte to push |
| pop_en | input | 1 | Pop one byte toward the host |
| pop_data | output | 8 | Popped byte, valid the cycle after the pop |
| pop_valid | output | 1 | Pop produced data last cycle |
| host_irq_clr | input | 1 | Host interrupt clear strobe |
| host_ack_we | input | 1 | Host read-acknowledge write strobe |
| host_ack_bit | input | 1 | 1 = ack, 0 = nack |
| host_irq | output | 1 | Interrupt toward the host |
| sw_irq | output | 1 | Interrupt toward local software |
| ack_status | output | 1 | Last acknowledge bit written by the host |
| trig_armed | output | 1 | Trigger armed state |
| thr_value | output | 8 | Stored (clamped) threshold |
| occupancy | output | 9 | Bytes currently queued |
| overflow_flag | output | 1 | Sticky: push dropped while full |
| underflow_flag | output | 1 | Sticky: pop dropped while empty |

## Verification
The bench sweeps every 8-bit threshold value. For each one it checks the clamp and then fills the queue byte by byte. The interrupt must stay low up to the last push and rise exactly one cycle after occupancy meets the threshold. A compare one byte early or late, or one that ignores the clamp at 0 or 129, fails this sweep. After each fire the bench clears the interrupt and pushes past the threshold again. A trigger that re-fires while disarmed, or that re-arms on the clear, raises the line here. Re-arming on an already full-enough queue must fire at once, so a design that waits for the next push misses. The bench also drives the same-cycle races (host clear against a fire, software clear against an acknowledge), full and empty queue abuse, and a full-depth order check.

// File: rtl/hti_pkg.sv
package hti_pkg;
  localparam int THR_W = 8;

  // Map a raw threshold into 1..cap.
  function automatic logic [THR_W-1:0] clamp_thr(input logic [THR_W-1:0] raw,
                                                 input logic [THR_W-1:0] cap);
    if (raw == '0)      return THR_W'(1);
    else if (raw > cap) return cap;
    else                return raw;
  endfunction
endpackage

// File: rtl/hti_fifo.sv
module hti_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_en,
  input  logic [DW-1:0]    push_data,
  input  logic             pop_en,
  output logic [DW-1:0]    pop_data,
  output logic             pop_valid,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             unf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic full, empty, push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_en && !full;
  assign pop_ok  = pop_en && !empty;

  // Storage and registered read kept free of reset for RAM inference.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
    if (pop_ok)  pop_data    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      pop_valid <= 1'b0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      pop_valid <= pop_ok;
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_en && full) ovf <= 1'b1;
      if (pop_en && empty) unf <= 1'b1;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (push_en && full && !pop_en) |=> (count == $past(count)) && ovf);
  assert_empty_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (pop_en && empty && !push_en) |=> !pop_valid && unf && (count == '0));
endmodule

// File: rtl/hti_trigger.sv
module hti_trigger
  import hti_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int BLOCK_MAX = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_thr_we,
  input  logic [THR_W-1:0] sw_thr_val,
  input  logic             host_clr,
  input  logic [CNT_W-1:0] occ,
  output logic             host_irq,
  output logic             armed,
  output logic [THR_W-1:0] thr
);
  localparam logic [THR_W-1:0] CAP = THR_W'(BLOCK_MAX);

  logic [THR_W-1:0] new_thr;
  logic fire_armed, fire_write, fire;

  assign new_thr    = clamp_thr(sw_thr_val, CAP);
  assign fire_armed = armed && (occ >= CNT_W'(thr));
  assign fire_write = sw_thr_we && (occ >= CNT_W'(new_thr));
  assign fire       = fire_armed || fire_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr      <= THR_W'(1);
      armed    <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      if (sw_thr_we) thr <= new_thr;
      if (fire)           armed <= 1'b0;
      else if (sw_thr_we) armed <= 1'b1;
      // A fire in the same cycle as a clear keeps the line high.
      if (fire)          host_irq <= 1'b1;
      else if (host_clr) host_irq <= 1'b0;
    end
  end

  assert_fire_disarms_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && occ >= CNT_W'(thr)) |=> host_irq && !armed);
  assert_rise_needs_arm_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(host_irq) |-> ($past(armed) || $past(sw_thr_we)));
  assert_clear_lowers_R4: assert property (@(posedge clk) disable iff (rst)
    (host_clr && !armed && !sw_thr_we) |=> !host_irq);
  assert_arm_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (!sw_thr_we && !armed) |=> !armed);
  assert_clear_race_R6: assert property (@(posedge clk) disable iff (rst)
    (host_clr && armed && occ >= CNT_W'(thr)) |=> host_irq);
  assert_thr_range_R1: assert property (@(posedge clk) disable iff (rst)
    (thr != '0) && (thr <= CAP));
endmodule

// File: rtl/hti_ack.sv
module hti_ack (
  input  logic clk,
  input  logic rst,
  input  logic ack_we,
  input  logic ack_bit,
  input  logic sw_clr,
  output logic sw_irq,
  output logic ack_st
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_irq <= 1'b0;
      ack_st <= 1'b0;
    end else begin
      if (ack_we) begin
        sw_irq <= 1'b1;
        ack_st <= ack_bit;
      end else if (sw_clr) begin
        sw_irq <= 1'b0;
      end
    end
  end

  assert_ack_raises_R7: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> sw_irq && (ack_st == $past(ack_bit)));
  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && !ack_we) |=> !sw_irq);
endmodule

// File: rtl/host_thresh_irq.sv
module host_thresh_irq
  import hti_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int BLOCK_MAX = 128,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_thr_we,
  input  logic [THR_W-1:0] sw_thr_val,
  input  logic             sw_irq_clr,
  input  logic             push_en,
  input  logic [7:0]       push_data,
  input  logic             pop_en,
  output logic [7:0]       pop_data,
  output logic             pop_valid,
  input  logic             host_irq_clr,
  input  logic             host_ack_we,
  input  logic             host_ack_bit,
  output logic             host_irq,
  output logic             sw_irq,
  output logic             ack_status,
  output logic             trig_armed,
  output logic [THR_W-1:0] thr_value,
  output logic [CNT_W-1:0] occupancy,
  output logic             overflow_flag,
  output logic             underflow_flag
);
  hti_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst(rst),
    .push_en(push_en), .push_data(push_data),
    .pop_en(pop_en), .pop_data(pop_data), .pop_valid(pop_valid),
    .count(occupancy), .ovf(overflow_flag), .unf(underflow_flag)
  );

  hti_trigger #(.CNT_W(CNT_W), .BLOCK_MAX(BLOCK_MAX)) u_trig (
    .clk(clk), .rst(rst),
    .sw_thr_we(sw_thr_we), .sw_thr_val(sw_thr_val),
    .host_clr(host_irq_clr), .occ(occupancy),
    .host_irq(host_irq), .armed(trig_armed), .thr(thr_value)
  );

  hti_ack u_ack (
    .clk(clk), .rst(rst),
    .ack_we(host_ack_we), .ack_bit(host_ack_bit), .sw_clr(sw_irq_clr),
    .sw_irq(sw_irq), .ack_st(ack_status)
  );
endmodule

// File: tb/tb_host_thresh_irq.sv
module tb_host_thresh_irq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_thr_we = 0, sw_irq_clr = 0, push_en = 0, pop_en = 0;
  logic host_irq_clr = 0, host_ack_we = 0, host_ack_bit = 0;
  logic [7:0] sw_thr_val = 0, push_data = 0;
  logic [7:0] pop_data, thr_value;
  logic pop_valid, host_irq, sw_irq, ack_status, trig_armed;
  logic overflow_flag, underflow_flag;
  logic [8:0] occupancy;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  host_thresh_irq dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs change at negedge; one posedge later the next negedge samples.
  task automatic tick();
    @(negedge clk);
    sw_thr_we = 0; sw_irq_clr = 0; push_en = 0; pop_en = 0;
    host_irq_clr = 0; host_ack_we = 0;
  endtask

  task automatic push(input logic [7:0] d);
    push_en = 1; push_data = d; tick();
  endtask
  task automatic pop();
    pop_en = 1; tick();
  endtask
  task automatic wr_thr(input logic [7:0] v);
    sw_thr_we = 1; sw_thr_val = v; tick();
  endtask
  task automatic hclr();
    host_irq_clr = 1; tick();
  endtask

  function automatic int clampv(input int v);
    if (v == 0) return 1;
    if (v > 128) return 128;
    return v;
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 occ", occupancy, 0);
    chk("R11 host_irq", host_irq, 0);
    chk("R11 sw_irq", sw_irq, 0);
    chk("R11 armed", trig_armed, 0);
    chk("R11 flags", {overflow_flag, underflow_flag, pop_valid}, 0);
    chk("R11 thr", thr_value, 1);

    // R9/R10 full depth order, overflow, underflow (trigger disarmed: R3)
    for (int i = 0; i < 256; i++) push(8'(i ^ 8'h5A));
    chk("R9 occ full", occupancy, 256);
    chk("R10 no ovf yet", overflow_flag, 0);
    push(8'hFF);
    chk("R10 ovf set", overflow_flag, 1);
    chk("R10 occ kept", occupancy, 256);
    chk("R3 no irq disarmed", host_irq, 0);
    for (int i = 0; i < 256; i++) begin
      pop();
      chk("R9 pop_valid", pop_valid, 1);
      chk("R9 order", pop_data, (i ^ 8'h5A) & 8'hFF);
    end
    chk("R9 occ empty", occupancy, 0);
    pop();
    chk("R10 unf set", underflow_flag, 1);
    chk("R10 no valid", pop_valid, 0);
    chk("R10 occ zero", occupancy, 0);
    tick();
    chk("R10 ovf sticky", overflow_flag, 1);

    // Exhaustive threshold sweep
    for (int t = 0; t < 256; t++) begin
      int e;
      e = clampv(t);
      while (occupancy != 0) pop();
      hclr();
      chk("R4 cleared", host_irq, 0);
      wr_thr(8'(t));
      chk("R1 thr", thr_value, e);
      chk("R1 armed", trig_armed, 1);
      for (int k = 1; k <= e; k++) begin
        push(8'(k));
        chk("R2 not early", host_irq, 0);
      end
      tick();
      chk("R2 fired", host_irq, 1);
      chk("R2 disarmed", trig_armed, 0);
      chk("R9 occ", occupancy, e);
      hclr();
      chk("R4 lowered", host_irq, 0);
      chk("R4 arm unchanged", trig_armed, 0);
      push(8'h11); push(8'h22); tick();
      chk("R3 ignored", host_irq, 0);
      chk("R3 still disarmed", trig_armed, 0);
      wr_thr(8'(t));
      chk("R5 immediate", host_irq, 1);
      chk("R5 disarmed", trig_armed, 0);
      hclr();
    end

    // R6 race: rewrite fire vs clear
    while (occupancy != 0) pop();
    push(1); push(2); push(3);
    wr_thr(2);
    chk("R6 setup", host_irq, 1);
    sw_thr_we = 1; sw_thr_val = 1; host_irq_clr = 1; tick();
    chk("R6 write wins", host_irq, 1);
    hclr();
    chk("R6 cleared", host_irq, 0);
    // R6 race: armed compare vs clear
    wr_thr(5);
    chk("R6 armed", trig_armed, 1);
    push(4); push(5);
    chk("R6 occ5", occupancy, 5);
    host_irq_clr = 1; tick();
    chk("R6 fire wins", host_irq, 1);
    chk("R6 disarm", trig_armed, 0);

    // R7/R8 acknowledge path
    host_ack_we = 1; host_ack_bit = 1; tick();
    chk("R7 sw_irq", sw_irq, 1);
    chk("R7 ack", ack_status, 1);
    sw_irq_clr = 1; tick();
    chk("R8 cleared", sw_irq, 0);
    chk("R7 status kept", ack_status, 1);
    sw_irq_clr = 1; host_ack_we = 1; host_ack_bit = 0; tick();
    chk("R8 ack wins", sw_irq, 1);
    chk("R7 nack", ack_status, 0);
    chk("R7 host_irq untouched", host_irq, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule